// File: doc/BRIEF.md
# Window-Timed Serial Nybble Port

This block is the digital core of a disk-style serial link. It is a bidirectional shift register placed between a parallel host side and a serial line that carries single-cycle transition pulses.

On receive, bit cells are timed by a counter that restarts from every accepted one, so the window does not follow a free-running clock. A pulse that arrives inside the current cell is a one. A cell that ends with no pulse is a zero. Bits shift into a register that starts cleared, and a nybble is complete at the moment a one reaches the top bit. The completed value is still in its line code: the block decodes nothing. If the line stays quiet for more than the allowed number of zero cells, the block reports an error, drops the partial nybble and waits for the next pulse to lock again.

On transmit, the host writes a byte into a holding register. The byte goes out MSB first, one cell per bit, and each one bit is a single-cycle pulse at the start of its cell. A flag tells the host when it may write the next byte. Consecutive bytes are sent with no gap between their cells.

Top module: `cell_nybble_port`

## Requirements
- R1: After reset, `rx_valid_o`, `zero_err_o` and `tx_pulse_o` are 0, `rx_data_o` is 0, `tx_empty_o` is 1, and the receiver is unlocked.
- R2: A pulse on `rd_pulse_i` is accepted as a one bit if it arrives 1 to `CELL_CYC` cycles after the current cell started. Each accepted one starts a new cell at its own edge. A pulse exactly `CELL_CYC` cycles after the cell start counts as a one, not as a zero.
- R3: While locked, a cell of `CELL_CYC` cycles with no pulse shifts a zero into the receive register.
- R4: A nybble is complete on the edge where a one reaches bit 7. On that edge the shifted value loads `rx_data_o` and `rx_valid_o` rises, and the shift register clears for the next nybble.
- R5: While `rx_valid_o` is 1 and no read is made, `rx_data_o` holds. Any nybble that completes in that time is dropped.
- R6: A one-cycle `rx_ack_i` clears `rx_valid_o` on the next edge, unless a new nybble completes on that same edge.
- R7: The zero cell that would make the run longer than `MAX_ZEROS` shifts nothing. It raises `zero_err_o` for exactly one cycle, discards the partial nybble and unlocks the receiver. No nybble completes from the discarded bits.
- R8: While unlocked, quiet cells are not counted and raise no further error. The next pulse locks the receiver and is taken as the leading one of a new nybble.
- R9: A byte written while the transmitter is idle starts its first cell on the edge after the write. Bits go out MSB first, one per `CELL_CYC` cycles. A one is a single-cycle high on `tx_pulse_o` in the first cycle of its cell, and a zero leaves the line low.
- R10: `tx_empty_o` is 1 while the holding register is free. A write made while it is 0 is ignored. A byte held during a transfer starts on the edge right after the last cell of the current byte, with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_pulse_i | input | 1 | Received transition pulse, one cycle per one bit |
| rx_data_o | output | NYB_W | Last completed nybble, still line-coded |
| rx_valid_o | output | 1 | `rx_data_o` holds an unread nybble |
| rx_ack_i | input | 1 | Host read strobe, clears `rx_valid_o` |
| zero_err_o | output | 1 | One-cycle pulse on a zero run longer than allowed |
| tx_data_i | input | NYB_W | Byte to transmit |
| tx_wr_i | input | 1 | Write strobe for `tx_data_i` |
| tx_empty_o | output | 1 | Transmit holding register is free |
| tx_pulse_o | output | 1 | Serial output, single-cycle pulse per one bit |

## Verification
A wrong cell count or a missed window restart shows up on the next zero cell. It gives a corrupted `rx_data_o` at completion, or a `zero_err_o` that comes early or late by a whole cell, within one nybble time. A zero-run counter that is not cleared by a one, or a partial nybble kept after an error, shows as a spurious error or a wrong value on the very next nybble. On transmit, a wrong bit counter or a late load from the holding register moves `tx_pulse_o` off its cell boundary, and this is visible at the first bit of the affected byte. The bench sweeps every nybble with a leading one at varying pulse offsets and compares each result with an error count it works out from the zero runs in that value.

// File: rtl/cnp_pkg.sv
package cnp_pkg;
  typedef enum logic {
    RX_HUNT = 1'b0,
    RX_LOCK = 1'b1
  } rx_mode_e;
endpackage

// File: rtl/cnp_cell_timer.sv
module cnp_cell_timer #(
  parameter int CELL_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CNT_W = $clog2(CELL_CYC);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_W'(CELL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (restart_i || !run_i || tick_o)  cnt_q <= '0;
    else                                     cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/cnp_rx.sv
module cnp_rx
  import cnp_pkg::*;
#(
  parameter int NYB_W     = 8,
  parameter int CELL_CYC  = 8,
  parameter int MAX_ZEROS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             ack_i,
  output logic [NYB_W-1:0] data_o,
  output logic             valid_o,
  output logic             err_o,
  output logic             done_o
);
  localparam int ZR_W = $clog2(MAX_ZEROS + 2);

  rx_mode_e         mode_q;
  logic [ZR_W-1:0]  zrun_q;
  logic [NYB_W-1:0] sh_q, sh_next;
  logic [NYB_W-1:0] data_q;
  logic             valid_q, err_q;
  logic             tick, zero_cell, zero_err, shift_en, done;

  cnp_cell_timer #(.CELL_CYC(CELL_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (mode_q == RX_LOCK),
    .restart_i(pulse_i),
    .tick_o   (tick)
  );

  // a pulse always wins over the end of the cell
  assign zero_cell = (mode_q == RX_LOCK) && tick && !pulse_i;
  assign zero_err  = zero_cell && (zrun_q == ZR_W'(MAX_ZEROS));
  assign shift_en  = pulse_i || (zero_cell && !zero_err);
  assign sh_next   = {sh_q[NYB_W-2:0], pulse_i};
  assign done      = shift_en && sh_next[NYB_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RX_HUNT;
      zrun_q <= '0;
      sh_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= zero_err;
      if (pulse_i) begin
        mode_q <= RX_LOCK;
        zrun_q <= '0;
      end else if (zero_err) begin
        mode_q <= RX_HUNT;
        zrun_q <= '0;
      end else if (zero_cell) begin
        zrun_q <= zrun_q + ZR_W'(1);
      end
      if (zero_err || done) sh_q <= '0;
      else if (shift_en)    sh_q <= sh_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (done && (!valid_q || ack_i)) begin
      data_q  <= sh_next;
      valid_q <= 1'b1;
    end else if (ack_i) begin
      valid_q <= 1'b0;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign done_o  = done;
endmodule

// File: rtl/cnp_tx.sv
module cnp_tx #(
  parameter int NYB_W    = 8,
  parameter int CELL_CYC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NYB_W-1:0] data_i,
  input  logic             wr_i,
  output logic             empty_o,
  output logic             pulse_o
);
  localparam int BC_W = $clog2(NYB_W + 1);

  logic [NYB_W-1:0] hold_q, sh_q;
  logic             full_q, busy_q, pulse_q;
  logic [BC_W-1:0]  bits_q;
  logic             tick, last_cell, adv, load;

  cnp_cell_timer #(.CELL_CYC(CELL_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy_q),
    .restart_i(load),
    .tick_o   (tick)
  );

  assign last_cell = busy_q && tick && (bits_q == BC_W'(1));
  assign adv       = busy_q && tick && (bits_q != BC_W'(1));
  assign load      = full_q && (!busy_q || last_cell);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (wr_i && !full_q) begin
      hold_q <= data_i;
      full_q <= 1'b1;
    end else if (load) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      bits_q  <= '0;
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else if (load) begin
      sh_q    <= hold_q;
      bits_q  <= BC_W'(NYB_W);
      busy_q  <= 1'b1;
      pulse_q <= hold_q[NYB_W-1];
    end else if (adv) begin
      sh_q    <= {sh_q[NYB_W-2:0], 1'b0};
      bits_q  <= bits_q - BC_W'(1);
      pulse_q <= sh_q[NYB_W-2];
    end else begin
      if (last_cell) busy_q <= 1'b0;
      pulse_q <= 1'b0;
    end
  end

  assign empty_o = !full_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/cell_nybble_port.sv
module cell_nybble_port #(
  parameter int NYB_W     = 8,
  parameter int CELL_CYC  = 8,
  parameter int MAX_ZEROS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_pulse_i,
  output logic [NYB_W-1:0] rx_data_o,
  output logic             rx_valid_o,
  input  logic             rx_ack_i,
  output logic             zero_err_o,
  input  logic [NYB_W-1:0] tx_data_i,
  input  logic             tx_wr_i,
  output logic             tx_empty_o,
  output logic             tx_pulse_o
);
  logic rx_done;

  cnp_rx #(
    .NYB_W    (NYB_W),
    .CELL_CYC (CELL_CYC),
    .MAX_ZEROS(MAX_ZEROS)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(rd_pulse_i),
    .ack_i  (rx_ack_i),
    .data_o (rx_data_o),
    .valid_o(rx_valid_o),
    .err_o  (zero_err_o),
    .done_o (rx_done)
  );

  cnp_tx #(
    .NYB_W   (NYB_W),
    .CELL_CYC(CELL_CYC)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (tx_data_i),
    .wr_i   (tx_wr_i),
    .empty_o(tx_empty_o),
    .pulse_o(tx_pulse_o)
  );
endmodule

// File: rtl/cnp_checks.sv
module cnp_checks #(
  parameter int NYB_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_ack_i,
  input logic             rx_done,
  input logic             rx_valid_o,
  input logic [NYB_W-1:0] rx_data_o,
  input logic             zero_err_o,
  input logic             tx_wr_i,
  input logic             tx_empty_o,
  input logic             tx_pulse_o
);
  a_r4_top_bit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> rx_data_o[NYB_W-1]);

  a_r5_hold_unread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ack_i) |=> (rx_valid_o && $stable(rx_data_o)));

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ack_i && !rx_done) |=> !rx_valid_o);

  a_r7_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_err_o |=> !zero_err_o);

  a_r9_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pulse_o |=> !tx_pulse_o);

  a_r10_write_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && tx_empty_o) |=> !tx_empty_o);
endmodule

bind cell_nybble_port cnp_checks #(.NYB_W(NYB_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rx_ack_i  (rx_ack_i),
  .rx_done   (rx_done),
  .rx_valid_o(rx_valid_o),
  .rx_data_o (rx_data_o),
  .zero_err_o(zero_err_o),
  .tx_wr_i   (tx_wr_i),
  .tx_empty_o(tx_empty_o),
  .tx_pulse_o(tx_pulse_o)
);

// File: tb/cell_nybble_port_bench.sv
`timescale 1ns/1ps
module cell_nybble_port_bench;
  localparam int CELL = 4;
  localparam int MAXZ = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_pulse = 1'b0;
  logic       rx_ack = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_wr = 1'b0;
  logic [7:0] rx_data_o;
  logic       rx_valid_o, zero_err_o, tx_empty_o, tx_pulse_o;

  int checks = 0;
  int errors = 0;
  int err_seen = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  cell_nybble_port #(.NYB_W(8), .CELL_CYC(CELL), .MAX_ZEROS(MAXZ)) u_cell_nybble_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_pulse_i(rd_pulse),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o),
    .rx_ack_i  (rx_ack),
    .zero_err_o(zero_err_o),
    .tx_data_i (tx_data),
    .tx_wr_i   (tx_wr),
    .tx_empty_o(tx_empty_o),
    .tx_pulse_o(tx_pulse_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive for one edge, sample after it at the falling edge
  task automatic cyc(input logic p);
    rd_pulse = p;
    @(negedge clk_i);
    rd_pulse = 1'b0;
    rx_ack   = 1'b0;
    tx_wr    = 1'b0;
    if (zero_err_o) err_seen++;
  endtask

  // first bit must be the leading one; j = pulse offset within its cell
  task automatic send_bits(input logic [31:0] b, input int n, input int j);
    int z = 0;
    cyc(1'b1);
    for (int i = n - 2; i >= 0; i--) begin
      if (b[i]) begin
        repeat (z * CELL + j - 1) cyc(1'b0);
        cyc(1'b1);
        z = 0;
      end else begin
        z++;
      end
    end
    repeat (z * CELL) cyc(1'b0);
  endtask

  task automatic desync();
    repeat ((MAXZ + 2) * CELL) cyc(1'b0);
    err_seen = 0;
  endtask

  task automatic host_read();
    rx_ack = 1'b1;
    cyc(1'b0);
  endtask

  function automatic int exp_errs(input logic [7:0] v);
    int z = 0;
    int e = 0;
    for (int i = 6; i >= 0; i--) begin
      if (v[i]) z = 0;
      else begin
        z++;
        if (z == MAXZ + 1) e++;
      end
    end
    return e;
  endfunction

  task automatic tx_pair(input logic [7:0] v1, input logic [7:0] v2);
    logic [15:0] pair = {v1, v2};
    int mism = 0;
    int bad_t = 0;
    int bad_a = 0;
    int bad_e = 0;
    logic e;
    repeat (10 * CELL) cyc(1'b0);
    tx_data = v1;
    tx_wr = 1'b1;
    cyc(1'b0);
    chk(!tx_empty_o, "R10 full after write", int'(tx_empty_o), 0);
    for (int t = 1; t <= 18 * CELL; t++) begin
      if (t == 3) begin
        chk(tx_empty_o, "R10 empty after load", int'(tx_empty_o), 1);
        tx_data = v2;
        tx_wr = 1'b1;
      end
      if (t == 5) begin
        tx_data = ~v2;
        tx_wr = 1'b1;
      end
      cyc(1'b0);
      e = ((t - 1) < 16 * CELL && ((t - 1) % CELL) == 0) ? pair[15 - (t - 1) / CELL] : 1'b0;
      if (tx_pulse_o !== e) begin
        if (mism == 0) begin
          bad_t = t;
          bad_a = int'(tx_pulse_o);
          bad_e = int'(e);
        end
        mism++;
      end
    end
    chk(mism == 0, $sformatf("R9/R10 serial pair %02h %02h at cycle %0d", v1, v2, bad_t), bad_a, bad_e);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(rx_valid_o == 1'b0 && zero_err_o == 1'b0 && rx_data_o == 8'h00, "R1 rx reset",
        {rx_valid_o, zero_err_o, rx_data_o}, 0);
    chk(tx_empty_o == 1'b1 && tx_pulse_o == 1'b0, "R1 tx reset", {tx_empty_o, tx_pulse_o}, 2);
    rst_ni = 1'b1;
    repeat (2 * MAXZ * CELL) cyc(1'b0);
    chk(err_seen == 0, "R1 unlocked after reset, no error", err_seen, 0);

    // R2/R3/R4/R6/R7 sweep of every value with a leading one
    for (int v = 128; v < 256; v++) begin
      int ee;
      desync();
      ee = exp_errs(8'(v));
      send_bits(32'(v), 8, 1 + (v % CELL));
      if (ee == 0) begin
        chk(rx_valid_o && rx_data_o == 8'(v) && err_seen == 0, "R2/R3/R4 nybble received",
            {rx_valid_o, err_seen[0], rx_data_o}, {1'b1, 1'b0, 8'(v)});
        host_read();
        chk(!rx_valid_o, "R6 read clears valid", int'(rx_valid_o), 0);
      end else begin
        chk(!rx_valid_o && err_seen == ee, $sformatf("R7 zero-run error for %02h", v),
            {rx_valid_o, 8'(err_seen)}, ee);
      end
    end

    // R5 hold while unread, second nybble dropped
    desync();
    send_bits(32'hAA, 8, 2);
    desync();
    send_bits(32'hB6, 8, 3);
    chk(rx_valid_o && rx_data_o == 8'hAA, "R5 unread nybble held", rx_data_o, 8'hAA);
    host_read();
    chk(!rx_valid_o, "R6 valid low after read, dropped nybble gone", int'(rx_valid_o), 0);

    // R7 partial discarded, then clean nybble
    desync();
    send_bits({18'd0, 6'b101000, 8'hDB}, 14, 2);
    chk(err_seen == 1, "R7 single error on partial", err_seen, 1);
    chk(rx_valid_o && rx_data_o == 8'hDB, "R7 partial bits discarded", rx_data_o, 8'hDB);
    host_read();

    // R8 long quiet gives one error only, then relock
    err_seen = 0;
    repeat (10 * CELL) cyc(1'b0);
    chk(err_seen == 1, "R8 one error over long quiet", err_seen, 1);
    err_seen = 0;
    send_bits(32'hB5, 8, CELL);
    chk(rx_valid_o && rx_data_o == 8'hB5 && err_seen == 0, "R8 relock on next pulse", rx_data_o, 8'hB5);
    host_read();

    // R9/R10 transmit
    tx_pair(8'hA5, 8'h00);
    tx_pair(8'hFF, 8'h81);
    tx_pair(8'h00, 8'h7E);
    tx_pair(8'h96, 8'h3C);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule